// File: doc/BRIEF.md
# Bit-Addressable Register with Demultiplex Mode

This block holds a word of single-bit storage cells, eight by default, and writes one of them at a time from a single data input. A binary select picks the cell. Two active-low control inputs choose one of four modes: addressed write, hold, one-hot demultiplex and clear. In demultiplex mode, the same hardware acts as a decoder with active-high outputs. The selected output carries the data bit, and every other output is forced low instead of keeping its value.

The design is fully synchronous. Inputs are sampled on the rising edge of `clk_i`, and the new word appears on `q_o` after that edge. An active-low asynchronous reset sets every cell to zero. Several blocks can be cascaded into a wider register by driving each block's enable from a decode of the upper address bits. While its enable is inactive, a block in hold mode keeps its contents.

Top module: `addr_latch`

## Requirements
- R1: While `rst_ni` is low, `q_o` is all zeros, and this takes effect without waiting for a clock edge.
- R2: With `clr_ni`=1 and `en_ni`=0 (write mode), on a rising edge bit `sel_i` of `q_o` takes `d_i`, and every other bit keeps its value.
- R3: With `clr_ni`=1 and `en_ni`=1 (hold mode), `q_o` does not change across a rising edge, whatever `d_i` and `sel_i` are.
- R4: With `clr_ni`=0 and `en_ni`=0 (demultiplex mode), after a rising edge bit `sel_i` of `q_o` equals `d_i`, and every other bit is 0.
- R5: With `clr_ni`=0 and `en_ni`=1 (clear mode), after a rising edge `q_o` is all zeros, whatever `d_i` and `sel_i` are.
- R6: A binary select value n addresses bit n of `q_o`. `sel_i`=0 selects bit 0 and `sel_i`=7 selects bit 7.
- R7: Moving from demultiplex mode to hold mode keeps the one-hot or all-zero pattern that demultiplex mode left on `q_o`.
- R8: Input changes between rising edges have no effect on `q_o` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all cells |
| d_i | input | 1 | Data bit for the addressed cell |
| sel_i | input | 3 | Binary address of the target bit |
| en_ni | input | 1 | Enable, active low |
| clr_ni | input | 1 | Clear/demultiplex control, active low |
| q_o | output | 8 | Stored word |

## Verification
Some mode transitions are hard to reach from the ports. In the demultiplex-to-hold transition of R7, a stale cell left over from earlier writes would hide a fault, so the demultiplex and clear steps must start from a word that already has bits set away from the target. The stimulus therefore performs an addressed write to a neighbouring bit before each mode step, which puts a 1 wherever a wrongly held bit would show. The exhaustive sweep runs every mode against every address and both data values, and mode changes happen on consecutive cycles. Mid-cycle input changes are checked before the next edge to cover R8.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/latch_mode_dec.sv
module latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic  clr_ni,
  input  logic  en_ni,
  output mode_e mode_o
);
  always_comb begin
    unique case ({clr_ni, en_ni})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/latch_sel_dec.sv
module latch_sel_dec #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NBITS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [NBITS-1:0] hit_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_hit
    assign hit_o[i] = (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/latch_bit_slice.sv
module latch_bit_slice
  import addr_latch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  hit_i,
  input  logic  d_i,
  output logic  q_o
);
  logic q_d;

  always_comb begin
    unique case (mode_i)
      MODE_WRITE: q_d = hit_i ? d_i : q_o;
      MODE_HOLD:  q_d = q_o;
      MODE_DEMUX: q_d = hit_i & d_i;
      default:    q_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NBITS = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_ni,
  input  logic             clr_ni,
  output logic [NBITS-1:0] q_o
);
  mode_e            mode;
  logic [NBITS-1:0] hit;

  latch_mode_dec i_mode_dec (
    .clr_ni (clr_ni),
    .en_ni  (en_ni),
    .mode_o (mode)
  );

  latch_sel_dec #(.SEL_W(SEL_W)) i_sel_dec (
    .sel_i (sel_i),
    .hit_o (hit)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_slice
    latch_bit_slice i_slice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .hit_i  (hit[i]),
      .d_i    (d_i),
      .q_o    (q_o[i])
    );
  end
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NBITS = 1 << SEL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             d_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             en_ni,
  input logic             clr_ni,
  input logic [NBITS-1:0] q_o
);
  logic [NBITS-1:0] mask;
  assign mask = {{(NBITS-1){1'b0}}, 1'b1} << sel_i;

  assert_reset_zero_R1: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);

  assert_write_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !en_ni) |=>
      ((q_o & $past(mask)) == ($past(d_i) ? $past(mask) : '0)) &&
      ((q_o & ~$past(mask)) == ($past(q_o) & ~$past(mask))));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && en_ni) |=> $stable(q_o));

  assert_demux_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !en_ni) |=> q_o == ($past(d_i) ? $past(mask) : '0));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && en_ni) |=> q_o == '0);

  assert_onehot_after_demux_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> $onehot0(q_o));
endmodule

bind addr_latch addr_latch_chk #(.SEL_W(SEL_W)) i_addr_latch_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .d_i    (d_i),
  .sel_i  (sel_i),
  .en_ni  (en_ni),
  .clr_ni (clr_ni),
  .q_o    (q_o)
);

// File: tb/test_addr_latch.sv
`timescale 1ns/1ps
module test_addr_latch;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned NBITS = 1 << SEL_W;
  localparam int unsigned NVEC  = 17;

  // {clr_ni, en_ni, sel, d, expected q}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 3'd0, 1'b1, 8'h01},
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h81},
    {1'b1, 1'b0, 3'd3, 1'b1, 8'h89},
    {1'b1, 1'b0, 3'd0, 1'b0, 8'h88},
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h88},
    {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},
    {1'b1, 1'b1, 3'd0, 1'b0, 8'h04},
    {1'b1, 1'b0, 3'd6, 1'b1, 8'h44},
    {1'b0, 1'b0, 3'd5, 1'b0, 8'h00},
    {1'b1, 1'b0, 3'd1, 1'b1, 8'h02},
    {1'b0, 1'b1, 3'd1, 1'b1, 8'h00},
    {1'b1, 1'b0, 3'd4, 1'b1, 8'h10},
    {1'b1, 1'b0, 3'd5, 1'b1, 8'h30},
    {1'b0, 1'b0, 3'd7, 1'b1, 8'h80},
    {1'b0, 1'b0, 3'd6, 1'b1, 8'h40},
    {1'b1, 1'b1, 3'd2, 1'b0, 8'h40},
    {1'b0, 1'b1, 3'd6, 1'b1, 8'h00}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             d_i;
  logic [SEL_W-1:0] sel_i;
  logic             en_ni;
  logic             clr_ni;
  logic [NBITS-1:0] q_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [NBITS-1:0] model = '0;

  always #5 clk_i = ~clk_i;

  addr_latch #(.SEL_W(SEL_W)) i_addr_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (d_i),
    .sel_i  (sel_i),
    .en_ni  (en_ni),
    .clr_ni (clr_ni),
    .q_o    (q_o)
  );

  task automatic check(input string req, input logic [NBITS-1:0] exp);
    n_chk++;
    if (q_o !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%h expected %h", req, q_o, exp);
    end
  endtask

  function automatic string tag_of(input logic c, input logic e);
    case ({c, e})
      2'b10:   return "R2";
      2'b11:   return "R3";
      2'b00:   return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [NBITS-1:0] ref_next(input logic c, input logic e,
                                                input logic [SEL_W-1:0] s, input logic d,
                                                input logic [NBITS-1:0] cur);
    logic [NBITS-1:0] r;
    r = cur;
    if (c && !e)       r[s] = d;
    else if (!c && !e) begin r = '0; r[s] = d; end
    else if (!c && e)  r = '0;
    return r;
  endfunction

  task automatic step(input logic c, input logic e, input logic [SEL_W-1:0] s,
                      input logic d, input string req, input bit do_chk);
    @(negedge clk_i);
    clr_ni = c; en_ni = e; sel_i = s; d_i = d;
    @(posedge clk_i);
    #1;
    model = ref_next(c, e, s, d, model);
    if (do_chk) check(req, model);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: q_o=%h expected completion", q_o);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; d_i = 1'b0; sel_i = '0; en_ni = 1'b1; clr_ni = 1'b1;
    #12;
    check("R1", '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8], tag_of(VEC[i][13], VEC[i][12]), 1'b0);
      check(tag_of(VEC[i][13], VEC[i][12]), VEC[i][7:0]);
    end

    // R6: walking write of each address from zero
    step(1'b0, 1'b1, '0, 1'b0, "R5", 1'b1);
    for (int s = 0; s < NBITS; s++) begin
      step(1'b1, 1'b0, SEL_W'(s), 1'b1, "R6", 1'b0);
      check("R6", NBITS'((2 ** (s + 1)) - 1));
    end

    // exhaustive sweep, neighbour bit preset before each step
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < NBITS; s++) begin
        for (int d = 0; d < 2; d++) begin
          step(1'b1, 1'b0, SEL_W'(s ^ 1), 1'b1, "R2", 1'b1);
          step(m[1], m[0], SEL_W'(s), d[0], tag_of(m[1], m[0]), 1'b1);
          if (m == 0) begin
            step(1'b1, 1'b1, SEL_W'(s ^ 3), ~d[0], "R7", 1'b1);
          end
        end
      end
    end

    // R8: mid-cycle change stays invisible until the edge
    step(1'b0, 1'b1, '0, 1'b0, "R5", 1'b1);
    @(negedge clk_i);
    clr_ni = 1'b1; en_ni = 1'b0; sel_i = 3'd4; d_i = 1'b1;
    #2;
    check("R8", '0);
    sel_i = 3'd2;
    @(posedge clk_i);
    #1;
    model = 8'h04;
    check("R8", model);

    // R1: asynchronous reset in mid-cycle
    step(1'b1, 1'b0, 3'd7, 1'b1, "R2", 1'b1);
    @(negedge clk_i);
    clr_ni = 1'b1; en_ni = 1'b1;
    #1;
    rst_ni = 1'b0;
    #1;
    check("R1", '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model = '0;
    step(1'b1, 1'b1, 3'd3, 1'b1, "R3", 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule